// File: doc/BRIEF.md
# Miss-Weighted Thread Criticality Tracker

This block estimates which core of a small chip multiprocessor is running the slowest, most poorly cached thread. It holds one saturating criticality counter per core. Each cache-miss pulse from a core adds a weight to that core's counter, and a second-level miss weighs far more than a first-level instruction or data miss. A programmable interval clears every counter at once, so the estimate follows recent behaviour rather than the whole run.

When a core runs out of work it raises a steal request and gives its own index. The block scans the counters of all other cores and, one cycle later, names the core with the highest count as the victim to steal from. If every other counter is zero, it answers that there is no victim. Work queues, the scheduler and the caches sit outside this block.

Two small state machines control it. The interval controller has the states `IV_HOLD` (refresh disabled, timer parked at zero) and `IV_TICK` (timer running). `IV_HOLD`→`IV_TICK` is taken when the bound becomes nonzero. `IV_TICK`→`IV_HOLD` is taken when the bound returns to zero. `IV_TICK`→`IV_TICK` either wraps the timer and fires a refresh or advances the timer. The reply controller has the states `RP_IDLE` and `RP_SEND`. It enters `RP_SEND` in the cycle after any cycle that carries a steal request, and it returns to `RP_IDLE` otherwise.

Top module: `crit_tracker`

## Requirements
- R1: Each core has its own 14-bit criticality counter. Reset clears every counter to 0 and holds `resp_valid` low.
- R2: An L1 instruction-miss pulse or an L1 data-miss pulse on a core adds 1 to that core's counter, one addition per pulse.
- R3: An L2-miss pulse adds 10 to the missing core's counter. When several miss pulses reach one core in the same cycle, their weights are summed: all three together add 12.
- R4: A counter saturates at 16383 and never wraps to a smaller value.
- R5: With `interval_bound` = B (nonzero), all counters clear together once every B cycles. The timer starts on the first clock after B becomes nonzero, and the first clear falls B cycles after that. A clear overrides any misses in the same cycle. B = 0 disables clearing.
- R6: A steal request sampled on a clock edge produces, on that edge, a response that names the core with the largest counter. The scan uses the counter values held before that edge's updates. `victim_hit` is 1 and `victim_id` is the core index.
- R7: When several cores share the maximum, the lowest-numbered of them is named.
- R8: The requesting core (`req_id`) is never named as its own victim.
- R9: If every counter other than the requester's is zero, the response has `victim_hit` = 0 and `victim_id` = 0.
- R10: `resp_valid` is high for exactly the cycle after each cycle in which `steal_req` is high, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1i_miss | input | NUM_CORES | Per-core L1 instruction-miss pulse |
| l1d_miss | input | NUM_CORES | Per-core L1 data-miss pulse |
| l2_miss | input | NUM_CORES | Per-core L2-miss pulse |
| interval_bound | input | BOUND_W | Refresh period in cycles; 0 disables refresh |
| steal_req | input | 1 | Steal request strobe |
| req_id | input | ID_W | Index of the requesting core |
| resp_valid | output | 1 | One-cycle pulse marking a response |
| victim_hit | output | 1 | The response names a victim |
| victim_id | output | ID_W | Index of the victim core, 0 when none |

## Verification
The bench targets several edges of the block's behaviour. The first is a counter pushed past 16383: a counter that wraps would drop to a small value and lose the steal to a core just below saturation. The second is a three-way miss in one cycle, which a design that applies only one weight would count as 10 or 1 instead of 12. It also checks an exact tie, where a scan that takes the last maximum would name the higher index, and a request from the core holding the maximum, where a scan that fails to exclude the requester would name that core itself. A long run with random misses and requests against a refresh period of 37 lands requests and misses on the clearing edge. A design that lets misses through the clear, or that scans the counters after that edge's update, then gives responses that differ from the reference model.

// File: rtl/crit_pkg.sv
package crit_pkg;

    typedef enum logic {
        IV_HOLD = 1'b0,
        IV_TICK = 1'b1
    } iv_state_t;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_SEND = 1'b1
    } rp_state_t;

endpackage

// File: rtl/crit_counter.sv
module crit_counter #(
    parameter int CNT_W = 14,
    parameter int L1_WT = 1,
    parameter int L2_WT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             l1i,
    input  logic             l1d,
    input  logic             l2,
    output logic [CNT_W-1:0] count
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << CNT_W) - 1);

    logic [SUM_W-1:0] add;
    logic [SUM_W-1:0] sum;

    always_comb begin
        add = '0;
        if (l1i) add = add + SUM_W'(L1_WT);
        if (l1d) add = add + SUM_W'(L1_WT);
        if (l2)  add = add + SUM_W'(L2_WT);
        sum = {1'b0, count} + add;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (clear)      count <= '0;
        else if (sum > MAXV) count <= MAXV[CNT_W-1:0];
        else                 count <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/crit_interval.sv
module crit_interval
    import crit_pkg::*;
#(
    parameter int BOUND_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BOUND_W-1:0] bound,
    output logic               refresh
);
    iv_state_t          st, st_nx;
    logic [BOUND_W-1:0] tmr, tmr_nx;
    logic               wrap;

    assign wrap = (bound != '0) && (tmr >= bound - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IV_HOLD;
            tmr <= '0;
        end else begin
            st  <= st_nx;
            tmr <= tmr_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        tmr_nx  = tmr;
        refresh = 1'b0;
        unique case (st)
            IV_HOLD: begin
                tmr_nx = '0;
                if (bound != '0) st_nx = IV_TICK;
            end
            IV_TICK: begin
                if (bound == '0) begin
                    st_nx  = IV_HOLD;
                    tmr_nx = '0;
                end else if (wrap) begin
                    refresh = 1'b1;
                    tmr_nx  = '0;
                end else begin
                    tmr_nx = tmr + 1'b1;
                end
            end
            default: st_nx = IV_HOLD;
        endcase
    end
endmodule

// File: rtl/crit_argmax.sv
module crit_argmax #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 14,
    parameter int ID_W      = 2
) (
    input  logic [NUM_CORES*CNT_W-1:0] counts,
    input  logic [ID_W-1:0]            skip_id,
    output logic [ID_W-1:0]            best_id,
    output logic                       found
);
    logic [CNT_W-1:0] best_val;

    always_comb begin
        best_val = '0;
        best_id  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if ((ID_W'(i) != skip_id) &&
                (counts[i*CNT_W +: CNT_W] > best_val)) begin
                best_val = counts[i*CNT_W +: CNT_W];
                best_id  = ID_W'(i);
            end
        end
        found = (best_val != '0);
    end
endmodule

// File: rtl/crit_tracker.sv
module crit_tracker
    import crit_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 14,
    parameter int BOUND_W   = 16,
    parameter int L1_WT     = 1,
    parameter int L2_WT     = 10,
    parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] l1i_miss,
    input  logic [NUM_CORES-1:0] l1d_miss,
    input  logic [NUM_CORES-1:0] l2_miss,
    input  logic [BOUND_W-1:0]   interval_bound,
    input  logic                 steal_req,
    input  logic [ID_W-1:0]      req_id,
    output logic                 resp_valid,
    output logic                 victim_hit,
    output logic [ID_W-1:0]      victim_id
);
    logic [NUM_CORES*CNT_W-1:0] cnt_flat;
    logic                       refresh;
    logic [ID_W-1:0]            scan_id;
    logic                       scan_found;
    logic [ID_W-1:0]            id_q;
    logic                       hit_q;
    rp_state_t                  rp_st;

    crit_interval #(.BOUND_W(BOUND_W)) u_iv (
        .clk(clk), .rst_n(rst_n), .bound(interval_bound), .refresh(refresh)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        crit_counter #(.CNT_W(CNT_W), .L1_WT(L1_WT), .L2_WT(L2_WT)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(refresh),
            .l1i(l1i_miss[g]), .l1d(l1d_miss[g]), .l2(l2_miss[g]),
            .count(cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    crit_argmax #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .ID_W(ID_W)) u_scan (
        .counts(cnt_flat), .skip_id(req_id),
        .best_id(scan_id), .found(scan_found)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_st <= RP_IDLE;
            id_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            unique case (rp_st)
                RP_IDLE: rp_st <= steal_req ? RP_SEND : RP_IDLE;
                RP_SEND: rp_st <= steal_req ? RP_SEND : RP_IDLE;
                default: rp_st <= RP_IDLE;
            endcase
            if (steal_req) begin
                id_q  <= scan_found ? scan_id : '0;
                hit_q <= scan_found;
            end
        end
    end

    always_comb begin
        resp_valid = 1'b0;
        victim_hit = 1'b0;
        victim_id  = '0;
        unique case (rp_st)
            RP_IDLE: ;
            RP_SEND: begin
                resp_valid = 1'b1;
                victim_hit = hit_q;
                victim_id  = id_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crit_tracker_chk.sv
module crit_tracker_chk #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 14,
    parameter int ID_W      = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       steal_req,
    input logic [ID_W-1:0]            req_id,
    input logic                       resp_valid,
    input logic                       victim_hit,
    input logic [ID_W-1:0]            victim_id,
    input logic                       refresh,
    input logic [NUM_CORES*CNT_W-1:0] cnt_flat
);
    // R10: a response follows each request cycle
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        steal_req |=> resp_valid);
    // R10: no response without a request
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !steal_req |=> !resp_valid);
    // R8: the requester is never its own victim
    a_r8_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        steal_req |=> (!victim_hit || victim_id != $past(req_id)));
    // R9: a "none" answer carries index 0
    a_r9_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !victim_hit) |-> victim_id == '0);
    // R5: a refresh empties every counter
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> cnt_flat == '0);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_mono
        // R4: without a refresh a counter never drops (no wrap)
        a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !refresh |=> cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W]));
    end
endmodule

bind crit_tracker crit_tracker_chk #(
    .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .steal_req(steal_req), .req_id(req_id),
    .resp_valid(resp_valid), .victim_hit(victim_hit), .victim_id(victim_id),
    .refresh(refresh), .cnt_flat(cnt_flat)
);

// File: tb/sim_crit_tracker.sv
`timescale 1ns/1ps
module sim_crit_tracker;
    localparam int N = 4;
    localparam int MAXC = 16383;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] l1i = '0, l1d = '0, l2 = '0;
    logic [15:0]  bound = '0;
    logic         steal_req = 1'b0;
    logic [1:0]   req_id = '0;
    logic         resp_valid, victim_hit;
    logic [1:0]   victim_id;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    crit_tracker u0 (
        .clk(clk), .rst_n(rst_n), .l1i_miss(l1i), .l1d_miss(l1d), .l2_miss(l2),
        .interval_bound(bound), .steal_req(steal_req), .req_id(req_id),
        .resp_valid(resp_valid), .victim_hit(victim_hit), .victim_id(victim_id)
    );

    // behavioural reference
    int m_cnt[N];
    bit m_on;
    int m_tick;
    bit e_valid, e_hit;
    int e_id;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_on = 0; m_tick = 0; e_valid = 0; e_hit = 0; e_id = 0;
        end else begin
            bit clr;
            if (steal_req) begin
                int best, bv;
                best = -1; bv = 0;
                for (int i = 0; i < N; i++)
                    if (i != int'(req_id) && m_cnt[i] > bv) begin bv = m_cnt[i]; best = i; end
                e_valid = 1; e_hit = (best >= 0); e_id = (best >= 0) ? best : 0;
            end else begin
                e_valid = 0; e_hit = 0; e_id = 0;
            end
            clr = 0;
            if (bound == 0) begin m_on = 0; m_tick = 0; end
            else if (!m_on) begin m_on = 1; m_tick = 0; end
            else if (m_tick >= int'(bound) - 1) begin clr = 1; m_tick = 0; end
            else m_tick++;
            for (int i = 0; i < N; i++) begin
                if (clr) m_cnt[i] = 0;
                else begin
                    m_cnt[i] += int'(l1i[i]) + int'(l1d[i]) + 10 * int'(l2[i]);
                    if (m_cnt[i] > MAXC) m_cnt[i] = MAXC;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 resp_valid", int'(resp_valid), int'(e_valid));
            if (e_valid) begin
                check("R6 victim_hit", int'(victim_hit), int'(e_hit));
                check("R6 victim_id", int'(victim_id), e_id);
            end
        end
    end

    task automatic probe(input int rq, input bit eh, input int eid, input string tag);
        steal_req = 1'b1; req_id = 2'(rq);
        @(negedge clk);
        steal_req = 1'b0;
        check({tag, " valid"}, int'(resp_valid), 1);
        check({tag, " hit"}, int'(victim_hit), int'(eh));
        check({tag, " id"}, int'(victim_id), eid);
    endtask

    task automatic pulse(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] c);
        l1i = a; l1d = b; l2 = c;
        @(negedge clk);
        l1i = '0; l1d = '0; l2 = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        check("R1 reset resp_valid", int'(resp_valid), 0);
        rst_n = 1'b1;
        idle(2);
        probe(0, 0, 0, "R1/R9 empty counters");
        // R2: L1 misses count 1
        pulse(4'b0010, 4'b0000, 4'b0000);
        pulse(4'b0000, 4'b0100, 4'b0000);
        pulse(4'b0000, 4'b0100, 4'b0000);
        probe(0, 1, 2, "R2 l1 weights");
        // R3: L2 weight 10
        pulse(4'b0000, 4'b0000, 4'b1000);
        probe(0, 1, 3, "R3 l2 weight");
        probe(3, 1, 2, "R8 exclude requester");
        // R3: summed weights, core1 = 1 + 12
        pulse(4'b0010, 4'b0010, 4'b0010);
        probe(0, 1, 1, "R3 summed");
        // R7: core2 2 + 11 = 13 ties core1
        pulse(4'b0100, 4'b0000, 4'b0100);
        probe(0, 1, 1, "R7 tie lowest");
        probe(1, 1, 2, "R8 tie with requester");
        // R5: interval refresh
        bound = 16'd20;
        idle(25);
        probe(3, 0, 0, "R5 refreshed");
        bound = 16'd0;
        pulse(4'b0100, 4'b0000, 4'b0000);
        idle(60);
        probe(0, 1, 2, "R5 refresh disabled");
        // R4: saturation
        bound = 16'd1;
        idle(3);
        bound = 16'd0;
        idle(1);
        for (int i = 0; i < 1639; i++) begin
            l2[0] = 1'b1;
            l2[1] = (i < 1638);
            l1i[1] = (i < 2);
            @(negedge clk);
        end
        l1i = '0; l2 = '0;
        probe(2, 1, 0, "R4 saturated wins");
        probe(0, 1, 1, "R4 second");
        // random phase: refresh edges, same-cycle scans (R5 R6)
        bound = 16'd37;
        for (int i = 0; i < 3000; i++) begin
            l1i = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            l1d = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            l2  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            steal_req = ($urandom_range(0, 3) == 0);
            req_id = 2'($urandom_range(0, 3));
            @(negedge clk);
        end
        l1i = '0; l1d = '0; l2 = '0; steal_req = 1'b0;
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule